// File: doc/BRIEF.md
# Banked Memory Select Decoder

This block turns the 16-bit address of an 8-bit processor into chip selects for a small system. It uses the top address nibble to pick one of three regions: RAM, ROM or the I/O area. Each region has an active-low select. The RAM select is gated by the phase-2 clock, so the RAM sees a strobe only in the data half of the cycle. The ROM and I/O selects follow the address alone.

The upper 8 KB of RAM space, from $8000 to $9FFF, is a banked window. In that window the decoder replaces RAM address bits 13 and 14 with the two low bits of a bank register. Below $8000 those bits pass straight through from the CPU. The bank register is three bits wide and is loaded through a write strobe with its own data bus. The I/O area is split into blocks of 16 bytes. A peripheral is chosen one-hot by a single address bit between A4 and A11. The four low address bits go out as the register offset inside the chosen block.

Top module: `bank_decoder`

## Requirements
- R1: For addresses $0000 to $9FFF, `ram_sel_n` is low exactly when `phi2` is high. `rom_sel_n` and `io_sel_n` stay high.
- R2: For addresses $B000 to $FFFF, `rom_sel_n` is low whatever the level of `phi2`. The other two region selects stay high.
- R3: For addresses $A000 to $AFFF, `io_sel_n` is low whatever the level of `phi2`. The other two region selects stay high.
- R4: At most one of `ram_sel_n`, `rom_sel_n` and `io_sel_n` is low at any time. In RAM space with `phi2` low, none of them is low.
- R5: `ram_a13` equals bank bit 0 when A15 is 1, and equals A13 when A15 is 0.
- R6: `ram_a14` equals bank bit 1 when A15 is 1, and equals A14 when A15 is 0.
- R7: In the I/O area, if exactly one of A4..A11 is high, `dev_sel[k]` is high for the bit A(4+k) and every other bit of `dev_sel` is low. `dev_off` always carries A3..A0.
- R8: `dev_sel` is all zero in each of these cases:
  - none of A4..A11 is high;
  - two or more of A4..A11 are high;
  - the address lies outside the I/O area.
- R9: After reset, `bank_q` reads 0.
- R10: When `bank_we` is high at a rising clock edge, `bank_q` takes `bank_din`. Without the strobe, `bank_q` holds its value. Bit 2 of the bank register has no effect on `ram_a13` or `ram_a14`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Phase-2 CPU clock level |
| addr | input | 16 | CPU address bus |
| bank_we | input | 1 | Bank register write strobe |
| bank_din | input | 3 | Bank number to load |
| ram_sel_n | output | 1 | Active-low RAM select |
| rom_sel_n | output | 1 | Active-low ROM select |
| io_sel_n | output | 1 | Active-low I/O area select |
| ram_a13 | output | 1 | Remapped RAM address bit 13 |
| ram_a14 | output | 1 | Remapped RAM address bit 14 |
| dev_sel | output | 8 | One-hot peripheral selects |
| dev_off | output | 4 | Register offset inside a peripheral block |
| bank_q | output | 3 | Current bank register value |

## Verification
The assertions assume that `addr`, `phi2`, `bank_we` and `bank_din` are settled at each rising edge of `clk`. They also assume that the strobe is a synchronous single-cycle request. The stimulus meets these assumptions by changing every input only on the falling edge. Results are compared 3 ns later, well before the next rising edge.

The address space is swept with a stride that is coprime to 16 in four bank states, and `phi2` is varied along the sweep. The I/O area is swept in full, with `phi2` both high and low.

// File: rtl/bank_decoder.sv
`timescale 1ns/1ps
module bank_decoder #(
  parameter int BANK_W  = 3,
  parameter int NDEV    = 8,
  parameter int DEV_LSB = 4,
  parameter logic [3:0] IO_NIB = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic [15:0]       addr,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_din,
  output logic              ram_sel_n,
  output logic              rom_sel_n,
  output logic              io_sel_n,
  output logic              ram_a13,
  output logic              ram_a14,
  output logic [NDEV-1:0]   dev_sel,
  output logic [DEV_LSB-1:0] dev_off,
  output logic [BANK_W-1:0] bank_q
);

  logic [3:0]      top_nib;
  logic            in_io, in_rom, in_ram, single;
  logic [NDEV-1:0] dev_bits;

  assign top_nib = addr[15:12];
  assign in_io   = (top_nib == IO_NIB);
  assign in_rom  = (top_nib > IO_NIB);
  assign in_ram  = !in_io && !in_rom;

  assign ram_sel_n = !(phi2 && in_ram);
  assign rom_sel_n = !in_rom;
  assign io_sel_n  = !in_io;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_din;

  assign ram_a13 = addr[15] ? bank_q[0] : addr[13];
  assign ram_a14 = addr[15] ? bank_q[1] : addr[14];

  assign dev_bits = addr[DEV_LSB +: NDEV];
  assign single   = (dev_bits != '0) && ((dev_bits & (dev_bits - 1'b1)) == '0);
  assign dev_sel  = (in_io && single) ? dev_bits : '0;
  assign dev_off  = addr[DEV_LSB-1:0];

  p_ram_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel_n |-> (phi2 && addr < 16'hA000));
  p_rom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hB000) |-> !rom_sel_n);
  p_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:12] == 4'hA) |-> (!io_sel_n && rom_sel_n && ram_sel_n));
  p_one_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_sel_n, ~rom_sel_n, ~io_sel_n}) <= 1);
  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:13] == 3'b100) |-> (ram_a13 == bank_q[0]));
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:13] == 3'b100) |-> (ram_a14 == bank_q[1]));
  p_dev_in_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel != '0) |-> !io_sel_n);
  p_dev_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));
  p_bank_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_q == $past(bank_din)));
  p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_q));

endmodule

// File: tb/bank_decoder_tb_top.sv
`timescale 1ns/1ps
module bank_decoder_tb_top;
  logic clk = 0, rst_n = 0, phi2 = 0, bank_we = 0;
  logic [15:0] addr = '0;
  logic [2:0]  bank_din = '0;
  logic ram_sel_n, rom_sel_n, io_sel_n, ram_a13, ram_a14;
  logic [7:0] dev_sel;
  logic [3:0] dev_off;
  logic [2:0] bank_q;

  int n_chk = 0, n_fail = 0;
  bit driving_done = 0;

  typedef struct {
    logic [15:0] a; logic p;
    logic ram_n, rom_n, io_n, a13, a14;
    logic [7:0] dev; logic [3:0] off;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr),
    .bank_we(bank_we), .bank_din(bank_din),
    .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n),
    .ram_a13(ram_a13), .ram_a14(ram_a14), .dev_sel(dev_sel),
    .dev_off(dev_off), .bank_q(bank_q));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic p, input logic [1:0] bk);
    exp_t e;
    int cnt;
    @(negedge clk);
    addr = a; phi2 = p;
    e.a = a; e.p = p;
    e.ram_n = !(a < 16'hA000 && p);
    e.io_n  = !(a >= 16'hA000 && a <= 16'hAFFF);
    e.rom_n = !(a >= 16'hB000);
    e.a13 = a[15] ? bk[0] : a[13];
    e.a14 = a[15] ? bk[1] : a[14];
    e.off = a[3:0];
    cnt = 0;
    for (int i = 4; i < 12; i++) if (a[i]) cnt++;
    e.dev = '0;
    if (!e.io_n && cnt == 1)
      for (int i = 4; i < 12; i++) e.dev[i-4] = a[i];
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #3;
      while (sb.size() > 0) begin
        exp_t e;
        string rq;
        e = sb.pop_front();
        rq = (e.a < 16'hA000) ? "R1" : (e.a >= 16'hB000) ? "R2" : "R3";
        n_chk++;
        if ({ram_sel_n, rom_sel_n, io_sel_n} != {e.ram_n, e.rom_n, e.io_n} ||
            ram_a13 != e.a13 || ram_a14 != e.a14 ||
            dev_sel != e.dev || dev_off != e.off) begin
          n_fail++;
          if ({ram_sel_n, rom_sel_n, io_sel_n} != {e.ram_n, e.rom_n, e.io_n})
            $display("FAIL %s/R4 addr %h phi2 %0b: actual %b expected %b", rq, e.a, e.p,
                     {ram_sel_n, rom_sel_n, io_sel_n}, {e.ram_n, e.rom_n, e.io_n});
          if (ram_a13 != e.a13 || ram_a14 != e.a14)
            $display("FAIL R5/R6 addr %h: actual %b expected %b", e.a,
                     {ram_a14, ram_a13}, {e.a14, e.a13});
          if (dev_sel != e.dev || dev_off != e.off)
            $display("FAIL R7/R8 addr %h: actual %h/%h expected %h/%h", e.a,
                     dev_sel, dev_off, e.dev, e.off);
        end
      end
    end
  end

  task automatic write_bank(input logic [2:0] v);
    @(negedge clk);
    bank_we = 1; bank_din = v;
    @(negedge clk);
    bank_we = 0; bank_din = ~v;
    #3 chk(bank_q == v, "R10 load", bank_q, v);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!driving_done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin : driver
    logic [2:0] banks [4];
    banks = '{3'b000, 3'b101, 3'b010, 3'b111};
    repeat (3) @(negedge clk);
    #3 chk(bank_q == 3'b000, "R9 reset", bank_q, 0);
    rst_n = 1;
    @(negedge clk); #3 chk(bank_q == 3'b000, "R9 after release", bank_q, 0);

    // R10: without the strobe the bank register ignores bank_din
    @(negedge clk); bank_din = 3'b110;
    @(negedge clk); #3 chk(bank_q == 3'b000, "R10 hold", bank_q, 0);

    foreach (banks[b]) begin
      write_bank(banks[b]);
      // R10: bit 2 never reaches the remap; expectation uses only bits 1:0
      for (int a = b; a < 65536; a += 7) drive(16'(a), a[3] ^ a[9], banks[b][1:0]);
      drive(16'h8000, 1'b1, banks[b][1:0]);
      drive(16'h9FFF, 1'b1, banks[b][1:0]);
      drive(16'h7FFF, 1'b1, banks[b][1:0]);
    end

    // R1/R3/R7/R8 boundaries and full I/O sweep with both phi2 levels
    drive(16'h9FFF, 1'b0, 2'b11);
    drive(16'hA000, 1'b1, 2'b11);
    drive(16'hAFFF, 1'b0, 2'b11);
    drive(16'hB000, 1'b0, 2'b11);
    drive(16'hFFFF, 1'b1, 2'b11);
    drive(16'h0000, 1'b0, 2'b11);
    drive(16'h0000, 1'b1, 2'b11);
    for (int a = 16'hA000; a <= 16'hAFFF; a++) begin
      drive(16'(a), 1'b0, 2'b11);
      drive(16'(a), 1'b1, 2'b11);
    end
    // R8: lone peripheral bit outside the I/O area selects nothing
    drive(16'h8010, 1'b1, 2'b11);
    drive(16'hB020, 1'b0, 2'b11);

    repeat (3) @(negedge clk);
    driving_done = 1;
    summary();
  end
endmodule